// File: doc/BRIEF.md
# Successive-Approximation Converter Control Logic

This block is the digital side of a 10-bit successive-approximation converter. It runs the bit-by-bit search against an external comparator. It keeps the user-visible configuration and status in a small register set, and it produces the select and enable signals for the analog front end. The sample-and-hold, DAC, comparator and references stay outside the block. The block drives a 10-bit trial code and a sample strobe, and it reads back one comparator bit: 1 means the held input is at or above the trial level.

Software writes a select register (input channel, reference source, result alignment), a control register (enable, start, trigger source, interrupt enable, completion flag) and a prescaler register. Each conversion starts from a software start or from a rising edge on one chosen trigger line. It spends one prescaled clock sampling and then one prescaled clock per result bit. It then latches the 10-bit code, sets a completion flag and, if enabled, raises an interrupt. The register port is a plain write strobe with a combinational read mux. There is no streaming interface, so no back-pressure rules apply.

Top module: `sar_adc_ctrl`

## Requirements
- R1: With a comparator that reports 1 exactly when the input level is at or above the trial code, the latched result equals the input level for every level 0 to 1023.
- R2: After the sampling period the first trial code is 0x200. Each later trial keeps or clears the bit under test and then sets the next lower bit, so with input level 0 the trials are 0x200, 0x100, ..., 0x001.
- R3: Select register (address 0): bits 3:0 are the channel (0-7 input pins, 8 bandgap, 9 ground), bits 5:4 the reference (0 external pin, 1 analog supply, 3 internal 1.1 V), bit 6 left alignment. While the enable bit is clear, writes are held pending and `ana_ch`/`ana_ref` do not change. While enabled, the pending values reach `ana_ch`/`ana_ref` on the second clock edge after the write.
- R4: Reset clears every register and output. Control register (address 1): bit 0 enable, bit 1 start, bits 4:2 trigger select, bit 5 interrupt enable, bit 6 completion flag. With enable clear, `ana_en` is low, no conversion starts, and clearing enable during a conversion abandons it without setting the flag.
- R5: Result bytes: address 3 is the low byte and address 4 the high byte of a 16-bit word. With bit 6 of the select register clear the result sits in bits 9:0, and with it set in bits 15:6. All unused bits read 0, and the choice applies to the stored result at once.
- R6: A trigger-select value k from 1 to 7 starts a conversion on a rising edge of `trig_in[k-1]`. Edges on other lines are ignored. Value 0 disables hardware starts.
- R7: Completion sets the flag (control bit 6). `irq` equals flag AND interrupt enable. Writing 1 to bit 6 clears the flag, and writing 0 leaves it unchanged.
- R8: Control bit 1 reads 1 while a conversion is in progress and 0 once the result is stored.
- R9: Prescaler register (address 2) bits 2:0 = k set the step period to 2^k system clocks for k = 1..7, and to 2 clocks for k = 0. Trial codes change only on prescaled ticks.
- R10: A start request (software or trigger) arriving while a conversion is in progress is ignored. It neither restarts sampling nor queues a second conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `bus_addr` |
| trig_in | input | 7 | Hardware start trigger lines |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| dac_code | output | 10 | Trial code to the DAC |
| sh_sample | output | 1 | Sample-and-hold tracking strobe |
| ana_en | output | 1 | Analog front-end enable |
| ana_ch | output | 4 | Applied channel select |
| ana_ref | output | 2 | Applied reference select |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The bench sweeps every input level through a behavioural comparator and reads each result in both alignments. A wrong keep/clear decision, or a bit resolved out of order, shows up as a mismatched code, and a wrong shift shows up as stray bits in the other byte. It times the gap between successive trial codes for each prescaler setting, which exposes a divider that is off by one power of two or that treats setting 0 as a divide-by-1. It writes the select register while disabled and restarts or aborts conversions in mid-flight. A design that leaks pending selects to the analog side, restarts sampling on a second start, or sets the flag after an abort would be reported. Trigger lines other than the selected one are pulsed to catch a mis-indexed trigger mux.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam logic [2:0] A_SEL  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_PRE  = 3'd2;
  localparam logic [2:0] A_RLO  = 3'd3;
  localparam logic [2:0] A_RHI  = 3'd4;

  localparam int C_EN  = 0;
  localparam int C_GO  = 1;
  localparam int C_TS  = 2;
  localparam int C_IE  = 5;
  localparam int C_FLG = 6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SAMP, SQ_CONV} sq_state_e;

  typedef struct packed {
    logic       left;
    logic [1:0] refs;
    logic [3:0] ch;
  } sel_t;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [PRE_W-1:0] shamt;

  // setting 0 behaves like setting 1 (divide by two)
  always_comb begin
    shamt = (div_sel == '0) ? PRE_W'(1) : div_sel;
    mask  = ~({CNT_W{1'b1}} << shamt);
  end

  assign tick = en && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             start,
  input  logic             cmp,
  output logic             busy,
  output logic             sample,
  output logic [RES_W-1:0] code,
  output logic             done,
  output logic [RES_W-1:0] result
);
  import sar_pkg::*;
  localparam int BIT_W = $clog2(RES_W);

  sq_state_e        state;
  logic [BIT_W-1:0] bidx;
  logic [RES_W-1:0] nxt;

  // decide the bit under test, then arm the next lower one
  always_comb begin
    nxt       = code;
    nxt[bidx] = cmp;
    if (bidx != '0) nxt[BIT_W'(bidx - 1'b1)] = 1'b1;
  end

  assign busy   = (state != SQ_IDLE);
  assign sample = (state == SQ_SAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      bidx   <= '0;
      code   <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= SQ_IDLE;
      end else begin
        unique case (state)
          SQ_IDLE: if (start) begin
            state <= SQ_SAMP;
            code  <= '0;
          end
          SQ_SAMP: if (tick) begin
            state <= SQ_CONV;
            bidx  <= BIT_W'(RES_W - 1);
            code  <= {1'b1, {(RES_W-1){1'b0}}};
          end
          SQ_CONV: if (tick) begin
            code <= nxt;
            if (bidx == '0) begin
              state  <= SQ_IDLE;
              done   <= 1'b1;
              result <= nxt;
            end else begin
              bidx <= bidx - 1'b1;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
  parameter int RES_W = 10,
  parameter int NTRIG = 7,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       rd_data,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             busy,
  input  logic             done,
  input  logic [RES_W-1:0] result,
  output logic             en,
  output logic [PRE_W-1:0] pre_sel,
  output logic             start_pulse,
  output logic [3:0]       ch_app,
  output logic [1:0]       ref_app,
  output logic             flag,
  output logic             irq
);
  import sar_pkg::*;
  localparam int TS_W   = $clog2(NTRIG + 1);
  localparam int WORD_W = 16;
  localparam int PAD    = WORD_W - RES_W;

  sel_t              sel_p;
  logic [TS_W-1:0]   tsel;
  logic              ie;
  logic [NTRIG-1:0]  trig_prev;
  logic [NTRIG-1:0]  rise;
  logic              trig_hit;
  logic              wr_ctrl;
  logic [WORD_W-1:0] word;
  logic              unused_wbit;

  assign unused_wbit = bus_wdata[7];
  assign wr_ctrl     = bus_wr && (bus_addr == A_CTRL);
  assign rise        = trig_in & ~trig_prev;

  always_comb begin
    trig_hit = 1'b0;
    for (int i = 0; i < NTRIG; i++)
      if (tsel == TS_W'(i + 1) && rise[i]) trig_hit = 1'b1;
  end

  // alignment follows the current select bit, not the one at completion
  assign word = sel_p.left ? {result, {PAD{1'b0}}} : {{PAD{1'b0}}, result};
  assign irq  = flag && ie;

  always_comb begin
    unique case (bus_addr)
      A_SEL:   rd_data = {1'b0, sel_p};
      A_CTRL:  rd_data = {1'b0, flag, ie, tsel, busy, en};
      A_PRE:   rd_data = {{(8-PRE_W){1'b0}}, pre_sel};
      A_RLO:   rd_data = word[7:0];
      A_RHI:   rd_data = word[15:8];
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_p       <= '0;
      tsel        <= '0;
      ie          <= 1'b0;
      en          <= 1'b0;
      pre_sel     <= '0;
      flag        <= 1'b0;
      start_pulse <= 1'b0;
      trig_prev   <= '0;
      ch_app      <= '0;
      ref_app     <= '0;
    end else begin
      trig_prev <= trig_in;
      if (bus_wr) begin
        unique case (bus_addr)
          A_SEL:  sel_p <= sel_t'(bus_wdata[6:0]);
          A_CTRL: begin
            en   <= bus_wdata[C_EN];
            tsel <= bus_wdata[C_TS +: TS_W];
            ie   <= bus_wdata[C_IE];
          end
          A_PRE:  pre_sel <= bus_wdata[PRE_W-1:0];
          default: ;
        endcase
      end
      if (done)                          flag <= 1'b1;
      else if (wr_ctrl && bus_wdata[C_FLG]) flag <= 1'b0;
      start_pulse <= (wr_ctrl && bus_wdata[C_GO] && bus_wdata[C_EN]) ||
                     (en && trig_hit);
      // pending selections reach the analog side only while enabled
      if (en) begin
        ch_app  <= sel_p.ch;
        ref_app <= sel_p.refs;
      end
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W = 10,
  parameter int NTRIG = 7,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       rd_data,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sh_sample,
  output logic             ana_en,
  output logic [3:0]       ana_ch,
  output logic [1:0]       ana_ref,
  output logic             irq
);
  logic             en;
  logic [PRE_W-1:0] pre_sel;
  logic             pre_tick;
  logic             start_pulse;
  logic             seq_busy;
  logic             seq_done;
  logic [RES_W-1:0] seq_result;
  logic             cc_flag;

  assign ana_en = en;

  sar_regs #(.RES_W(RES_W), .NTRIG(NTRIG), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .trig_in(trig_in),
    .busy(seq_busy), .done(seq_done), .result(seq_result),
    .en(en), .pre_sel(pre_sel), .start_pulse(start_pulse),
    .ch_app(ana_ch), .ref_app(ana_ref), .flag(cc_flag), .irq(irq)
  );

  sar_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(pre_sel), .tick(pre_tick)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(pre_tick),
    .start(start_pulse), .cmp(cmp_in),
    .busy(seq_busy), .sample(sh_sample), .code(dac_code),
    .done(seq_done), .result(seq_result)
  );
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ana_en,
  input logic             busy,
  input logic             sh_sample,
  input logic             tick,
  input logic             done,
  input logic             flag,
  input logic [RES_W-1:0] dac_code,
  input logic [3:0]       ana_ch,
  input logic [1:0]       ana_ref
);
  AST_TRIAL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(dac_code)); // R2

  AST_HOLD_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_en |=> ($stable(ana_ch) && $stable(ana_ref))); // R3

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_en |=> !busy); // R4

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag); // R7

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R9

  AST_NO_RESAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sh_sample) |=> !sh_sample); // R10
endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ana_en(ana_en), .busy(seq_busy),
  .sh_sample(sh_sample), .tick(pre_tick), .done(seq_done),
  .flag(cc_flag), .dac_code(dac_code), .ana_ch(ana_ch), .ana_ref(ana_ref)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
  import sar_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic [6:0] trig_in;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       sh_sample, ana_en, irq;
  logic [3:0] ana_ch;
  logic [1:0] ana_ref;

  always #4 clk = ~clk;

  int vin = 0;
  assign cmp_in = (vin >= int'(dac_code));

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .trig_in(trig_in),
    .cmp_in(cmp_in), .dac_code(dac_code), .sh_sample(sh_sample),
    .ana_en(ana_en), .ana_ch(ana_ch), .ana_ref(ana_ref), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // trial-code log and sample-strobe counter
  int cyc = 0;
  always @(posedge clk) cyc++;
  logic [9:0] dac_d = '0;
  logic       sh_d = 1'b0;
  int         nlog = 0, sh_rises = 0;
  logic [9:0] lval [16];
  int         lt   [16];
  always @(negedge clk) begin
    if (dac_code !== dac_d) begin
      if (nlog < 16) begin lval[nlog] = dac_code; lt[nlog] = cyc; end
      nlog++;
      dac_d = dac_code;
    end
    if (sh_sample && !sh_d) sh_rises++;
    sh_d = sh_sample;
  end

  function automatic logic [7:0] cbyte(bit en, bit go, logic [2:0] ts, bit ie, bit clr);
    return {1'b0, clr, ie, ts, go, en};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_res(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(A_RLO, lo);
    rd(A_RHI, hi);
    w = {hi, lo};
  endtask

  task automatic start_conv(input bit ie);
    wr(A_CTRL, cbyte(1, 1, 3'd0, ie, 1));
  endtask

  task automatic wait_flag(input int lim, output bit got);
    logic [7:0] d;
    got = 0;
    for (int i = 0; i < lim; i++) begin
      rd(A_CTRL, d);
      if (d[C_FLG]) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] w;
    bit          got;
    int          rs, idx;

    rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; trig_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check(d == 8'h00, "R4 reset register", d, 0);
    end
    check(!ana_en && !irq && !sh_sample, "R4 reset outputs", {ana_en, irq, sh_sample}, 0);

    // R3: pending selection while disabled, applied once enabled
    wr(A_SEL, 8'h35);
    repeat (3) @(negedge clk);
    check(ana_ch == 4'd0 && ana_ref == 2'd0, "R3 held while disabled", {ana_ref, ana_ch}, 0);
    rd(A_SEL, d);
    check(d == 8'h35, "R3 pending readback", d, 8'h35);
    wr(A_CTRL, cbyte(1, 0, 3'd0, 0, 0));
    @(negedge clk);
    check(ana_ch == 4'd5 && ana_ref == 2'd3, "R3 applied on enable", {ana_ref, ana_ch}, 8'h35);
    wr(A_SEL, 8'h19);
    @(negedge clk);
    check(ana_ch == 4'd9 && ana_ref == 2'd1, "R3 write while enabled", {ana_ref, ana_ch}, 8'h19);
    wr(A_CTRL, cbyte(0, 0, 3'd0, 0, 0));
    wr(A_SEL, 8'h08);
    repeat (3) @(negedge clk);
    check(ana_ch == 4'd9 && ana_ref == 2'd1, "R3 held after disable", {ana_ref, ana_ch}, 8'h19);

    // R4: start while disabled is ignored
    rs = sh_rises;
    wr(A_CTRL, cbyte(0, 1, 3'd0, 0, 0));
    repeat (40) @(negedge clk);
    rd(A_CTRL, d);
    check(sh_rises == rs && d[C_GO] == 0 && d[C_FLG] == 0, "R4 no start while disabled", d, 0);

    // R2: trial order, MSB first, input level 0
    wr(A_PRE, 8'h00);
    vin = 0;
    wr(A_CTRL, cbyte(1, 0, 3'd0, 0, 0));
    nlog = 0;
    start_conv(0);
    wait_flag(500, got);
    check(got, "R2 conversion completes", got, 1);
    check(nlog >= 10, "R2 trial count", nlog, 10);
    for (int i = 0; i < 10; i++)
      check(lval[i] == (10'h200 >> i), "R2 trial code", lval[i], 10'h200 >> i);

    // R9: step period per prescaler setting, full-scale input
    vin = 1023;
    for (int k = 0; k < 8; k++) begin
      wr(A_PRE, 8'(k));
      nlog = 0;
      start_conv(0);
      wait_flag(3000, got);
      idx = -1;
      for (int i = 0; i < 15 && i < nlog; i++)
        if (idx < 0 && lval[i] == 10'h200) idx = i;
      check(idx >= 0 && lt[idx+1] - lt[idx] == (1 << ((k == 0) ? 1 : k)),
            "R9 step period", (idx >= 0) ? lt[idx+1] - lt[idx] : -1, 1 << ((k == 0) ? 1 : k));
      rd_res(w);
      check(w == 16'h03FF, "R1 full scale", w, 16'h03FF);
    end

    // R1/R5: every input level, both alignments
    wr(A_PRE, 8'h01);
    for (int v = 0; v < 1024; v++) begin
      vin = v;
      start_conv(0);
      wait_flag(200, got);
      rd_res(w);
      check(got && w == 16'(v), "R1 result right-aligned", w, v);
      wr(A_SEL, 8'h48);
      rd_res(w);
      check(w == 16'(v << 6), "R5 result left-aligned", w, v << 6);
      wr(A_SEL, 8'h08);
    end

    // R8: start bit reflects conversion in progress
    wr(A_PRE, 8'h07);
    vin = 300;
    start_conv(0);
    repeat (20) @(negedge clk);
    rd(A_CTRL, d);
    check(d[C_GO] == 1, "R8 busy during conversion", d[C_GO], 1);
    wait_flag(3000, got);
    rd(A_CTRL, d);
    check(d[C_GO] == 0, "R8 clear after result", d[C_GO], 0);
    rd_res(w);
    check(w == 16'd300, "R1 slow conversion", w, 300);

    // R7: flag, interrupt enable, write-one-to-clear
    check(irq == 0, "R7 irq masked", irq, 0);
    wr(A_CTRL, cbyte(1, 0, 3'd0, 1, 0));
    check(irq == 1, "R7 irq on enable", irq, 1);
    rd(A_CTRL, d);
    check(d[C_FLG] == 1, "R7 writing 0 keeps flag", d[C_FLG], 1);
    wr(A_CTRL, cbyte(1, 0, 3'd0, 1, 1));
    rd(A_CTRL, d);
    check(d[C_FLG] == 0 && irq == 0, "R7 flag cleared by 1", {d[C_FLG], irq}, 0);
    wr(A_PRE, 8'h01);
    vin = 77;
    start_conv(1);
    wait_flag(200, got);
    check(got && irq == 1, "R7 irq at completion", irq, 1);

    // R6: trigger selection
    vin = 500;
    wr(A_CTRL, cbyte(1, 0, 3'd3, 0, 1));
    @(negedge clk); trig_in = 7'b0001011;
    @(negedge clk); trig_in = '0;
    repeat (60) @(negedge clk);
    rd(A_CTRL, d);
    check(d[C_FLG] == 0, "R6 unselected lines ignored", d[C_FLG], 0);
    trig_in = 7'b0000100;
    repeat (2) @(negedge clk);
    trig_in = '0;
    wait_flag(200, got);
    rd_res(w);
    check(got && w == 16'd500, "R6 selected line starts", w, 500);
    wr(A_CTRL, cbyte(1, 0, 3'd0, 0, 1));
    @(negedge clk); trig_in = 7'h7F;
    @(negedge clk); trig_in = '0;
    repeat (60) @(negedge clk);
    rd(A_CTRL, d);
    check(d[C_FLG] == 0, "R6 select 0 disables triggers", d[C_FLG], 0);

    // R10: start during conversion ignored
    wr(A_PRE, 8'h05);
    vin = 612;
    rs = sh_rises;
    start_conv(0);
    repeat (100) @(negedge clk);
    wr(A_CTRL, cbyte(1, 1, 3'd0, 0, 0));
    wait_flag(2000, got);
    repeat (600) @(negedge clk);
    check(sh_rises - rs == 1, "R10 single sampling", sh_rises - rs, 1);
    rd_res(w);
    check(got && w == 16'd612, "R10 result unaffected", w, 612);

    // R4: abort by clearing enable
    wr(A_PRE, 8'h07);
    vin = 100;
    start_conv(0);
    repeat (200) @(negedge clk);
    wr(A_CTRL, cbyte(0, 0, 3'd0, 0, 0));
    repeat (2000) @(negedge clk);
    rd(A_CTRL, d);
    check(d[C_FLG] == 0 && d[C_GO] == 0 && !ana_en && !sh_sample,
          "R4 abort leaves flag clear", d, 0);

    finish_run();
  end
endmodule